// File: doc/BRIEF.md
# DMA Receive Transfer Terminator

This block supervises a single DMA transfer that drains received USB OUT packets from an endpoint buffer toward a local bus. Software programs a byte budget and issues a start command. Each accepted packet reduces the budget by its length. The transfer ends for one of four reasons: the budget runs out, a packet shorter than the endpoint's maximum packet size (including a zero-length packet) arrives, software requests a stop, or software requests a reset.

Each ending cause is recorded in its own sticky reason flag. Software clears a flag by writing a one to that flag's bit. An interrupt line is raised while any flag that is also enabled in a per-flag mask is set. A packet longer than the remaining budget is truncated to the budget, and the excess is reported in a separate overflow flag. The packet source and the bus master sit outside the block. The block only sees a packet strobe with its byte length.

Top module: `dma_term_ctrl`

## Requirements
- R1: After rst_n is deasserted, busy is 0, remaining is 0, reason is 0 and irq is 0.
- R2: A start command while idle with a nonzero count sets busy to 1 and remaining to that count on the next cycle.
- R3: While busy, a packet whose length is at least max_pkt and less than remaining reduces remaining by the length and leaves busy at 1.
- R4: A packet that is not short and brings remaining exactly to zero clears busy and sets only reason bit 0 (transfer complete).
- R5: While busy, a packet with length below max_pkt (a zero-length packet included) clears busy, sets reason bit 1 (end of transfer) and reduces remaining by the accepted length.
- R6: A short packet that also brings remaining to zero sets reason bits 0 and 1 in the same cycle.
- R7: A stop command while busy clears busy and sets reason bit 2 (stopped), and a packet presented in the same cycle is ignored, so remaining is unchanged.
- R8: A reset command clears busy, remaining and every reason bit on the next cycle, and sets no reason bit.
- R9: Reason bits are sticky until written with 1 on flag_clr, each bit individually; when a bit is set and cleared in the same cycle, it ends up set.
- R10: irq is 1 exactly when some reason bit is 1 and the matching irq_en bit is 1.
- R11: A start command while busy is ignored; remaining and busy keep their values.
- R12: A start command with a count of zero leaves busy at 0 and sets only reason bit 0.
- R13: A packet longer than remaining accepts only the remaining bytes, drives remaining to 0, ends the transfer and sets reason bits 0 and 3 (overflow).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start strobe, loads cmd_count |
| cmd_count | input | CNT_W | Byte budget for the transfer |
| cmd_stop | input | 1 | Stop strobe |
| cmd_reset | input | 1 | Reset strobe, returns block to power-on state |
| max_pkt | input | LEN_W | Endpoint maximum packet size in bytes |
| pkt_valid | input | 1 | Packet received strobe |
| pkt_len | input | LEN_W | Byte length of the received packet |
| flag_clr | input | 4 | Write-one-to-clear for reason bits |
| irq_en | input | 4 | Per-flag interrupt enable mask |
| busy | output | 1 | Transfer in progress |
| remaining | output | CNT_W | Bytes still to be accepted |
| reason | output | 4 | Sticky reason flags: 0 complete, 1 end of transfer, 2 stopped, 3 overflow |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act in the same cycle. In one, a software write-one-to-clear hits a reason bit in the cycle that a terminating packet sets it. The bench provokes this with an overflowing packet and a clear of both bits it raises, and expects both bits to remain set afterwards. In the other, a stop command meets a packet strobe. The bench judges this by the stopped flag alone being set and the remaining count not moving.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;

    localparam int NUM_FLAGS = 4;

    localparam int FLG_DONE = 0;
    localparam int FLG_EOT  = 1;
    localparam int FLG_HALT = 2;
    localparam int FLG_OVF  = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/dma_term_count.sv
module dma_term_count #(
    parameter int CNT_W = 16,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             take,
    input  logic [LEN_W-1:0] take_len,
    output logic [CNT_W-1:0] rem_q,
    output logic             hits_zero,
    output logic             overflow
);

    localparam int W = (CNT_W > LEN_W) ? CNT_W : LEN_W;

    typedef struct packed {
        logic [CNT_W-1:0] rem;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [W-1:0] len_w, rem_w, acc_w, next_w;

    always_comb begin
        len_w     = W'(take_len);
        rem_w     = W'(cnt_q.rem);
        overflow  = len_w > rem_w;
        hits_zero = len_w >= rem_w;
        acc_w     = overflow ? rem_w : len_w;
        next_w    = rem_w - acc_w;
        cnt_d     = cnt_q;
        if (wipe) begin
            cnt_d.rem = '0;
        end else if (take) begin
            cnt_d.rem = next_w[CNT_W-1:0];
        end else if (load) begin
            cnt_d.rem = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign rem_q = cnt_q.rem;

    assert_drain_to_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe && take && (len_w >= rem_w)) |=> (rem_q == '0));

endmodule

// File: rtl/dma_term_flags.sv
module dma_term_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wipe,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] flags_q,
    output logic         irq
);

    typedef struct packed {
        logic [N-1:0] flags;
    } flg_t;

    flg_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (wipe) begin
            flg_d.flags = '0;
        end else begin
            flg_d.flags = (flg_q.flags & ~clr_i) | set_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign flags_q = flg_q.flags;
    assign irq     = |(flg_q.flags & en_i);

    for (genvar k = 0; k < N; k++) begin : g_sticky
        assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!wipe && flags_q[k] && !clr_i[k]) |=> flags_q[k]);
        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!wipe && set_i[k]) |=> flags_q[k]);
    end

endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl
    import dma_term_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LEN_W = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_start,
    input  logic [CNT_W-1:0]     cmd_count,
    input  logic                 cmd_stop,
    input  logic                 cmd_reset,
    input  logic [LEN_W-1:0]     max_pkt,
    input  logic                 pkt_valid,
    input  logic [LEN_W-1:0]     pkt_len,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    input  logic [NUM_FLAGS-1:0] irq_en,
    output logic                 busy,
    output logic [CNT_W-1:0]     remaining,
    output logic [NUM_FLAGS-1:0] reason,
    output logic                 irq
);

    typedef struct packed {
        run_state_e st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 do_load, do_take, is_short;
    logic                 hits_zero, overflow;
    logic [NUM_FLAGS-1:0] set_v;

    always_comb begin
        ctl_d    = ctl_q;
        set_v    = '0;
        do_load  = 1'b0;
        do_take  = 1'b0;
        is_short = pkt_len < max_pkt;
        if (cmd_reset) begin
            ctl_d.st = ST_IDLE;
        end else if (ctl_q.st == ST_RUN) begin
            if (cmd_stop) begin
                ctl_d.st        = ST_IDLE;
                set_v[FLG_HALT] = 1'b1;
            end else if (pkt_valid) begin
                do_take         = 1'b1;
                set_v[FLG_EOT]  = is_short;
                set_v[FLG_DONE] = hits_zero;
                set_v[FLG_OVF]  = overflow;
                if (is_short || hits_zero) begin
                    ctl_d.st = ST_IDLE;
                end
            end
        end else if (cmd_start) begin
            if (cmd_count == '0) begin
                set_v[FLG_DONE] = 1'b1;
            end else begin
                do_load  = 1'b1;
                ctl_d.st = ST_RUN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy = (ctl_q.st == ST_RUN);

    dma_term_count #(
        .CNT_W(CNT_W),
        .LEN_W(LEN_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe     (cmd_reset),
        .load     (do_load),
        .load_val (cmd_count),
        .take     (do_take),
        .take_len (pkt_len),
        .rem_q    (remaining),
        .hits_zero(hits_zero),
        .overflow (overflow)
    );

    dma_term_flags #(
        .N(NUM_FLAGS)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wipe   (cmd_reset),
        .set_i  (set_v),
        .clr_i  (flag_clr),
        .en_i   (irq_en),
        .flags_q(reason),
        .irq    (irq)
    );

    assert_stop_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_stop && !cmd_reset) |=> (!busy && reason[FLG_HALT] && $stable(remaining)));

    assert_reset_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (!busy && reason == '0 && remaining == '0));

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start && !cmd_stop && !cmd_reset && !pkt_valid) |=> (busy && $stable(remaining)));

    assert_short_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pkt_valid && (pkt_len < max_pkt) && !cmd_stop && !cmd_reset)
            |=> (!busy && reason[FLG_EOT]));

    assert_zero_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start && cmd_count == '0 && !cmd_reset) |=> (!busy && reason[FLG_DONE]));

endmodule

// File: tb/sim_dma_term_ctrl.sv
module sim_dma_term_ctrl;

    localparam int CNT_W = 16;
    localparam int LEN_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_start = 1'b0;
    logic [CNT_W-1:0] cmd_count = '0;
    logic             cmd_stop = 1'b0;
    logic             cmd_reset = 1'b0;
    logic [LEN_W-1:0] max_pkt = 11'd512;
    logic             pkt_valid = 1'b0;
    logic [LEN_W-1:0] pkt_len = '0;
    logic [3:0]       flag_clr = '0;
    logic [3:0]       irq_en = 4'hF;
    logic             busy;
    logic [CNT_W-1:0] remaining;
    logic [3:0]       reason;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dma_term_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_count(cmd_count),
        .cmd_stop(cmd_stop), .cmd_reset(cmd_reset), .max_pkt(max_pkt),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .flag_clr(flag_clr),
        .irq_en(irq_en), .busy(busy), .remaining(remaining), .reason(reason), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        cmd_start = 1'b0; cmd_stop = 1'b0; cmd_reset = 1'b0;
        pkt_valid = 1'b0; flag_clr = '0;
    endtask

    task automatic start(input int n);
        cmd_start = 1'b1; cmd_count = CNT_W'(n); cyc();
    endtask

    task automatic pkt(input int n);
        pkt_valid = 1'b1; pkt_len = LEN_W'(n); cyc();
    endtask

    task automatic clear_all();
        flag_clr = 4'hF; cyc();
    endtask

    task automatic t_reset_state();
        chk("R1 busy", busy, 0);
        chk("R1 remaining", remaining, 0);
        chk("R1 reason", reason, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_full_packets();
        start(1024);
        chk("R2 busy", busy, 1);
        chk("R2 remaining", remaining, 1024);
        pkt(512);
        chk("R3 remaining", remaining, 512);
        chk("R3 busy", busy, 1);
        pkt(512);
        chk("R4 busy", busy, 0);
        chk("R4 remaining", remaining, 0);
        chk("R4 reason", reason, 4'b0001);
        chk("R10 irq set", irq, 1);
        flag_clr = 4'b0001; cyc();
        chk("R9 cleared", reason, 0);
        chk("R10 irq clear", irq, 0);
    endtask

    task automatic t_short_packets();
        start(1000);
        pkt(100);
        chk("R5 busy", busy, 0);
        chk("R5 remaining", remaining, 900);
        chk("R5 reason", reason, 4'b0010);
        clear_all();
        start(50);
        pkt(0);
        chk("R5 zero-length busy", busy, 0);
        chk("R5 zero-length remaining", remaining, 50);
        chk("R5 zero-length reason", reason, 4'b0010);
        clear_all();
    endtask

    task automatic t_short_final();
        start(600);
        pkt(512);
        chk("R3 remaining", remaining, 88);
        pkt(88);
        chk("R6 busy", busy, 0);
        chk("R6 remaining", remaining, 0);
        chk("R6 reason", reason, 4'b0011);
        clear_all();
    endtask

    task automatic t_stop();
        start(2000);
        cmd_stop = 1'b1; pkt_valid = 1'b1; pkt_len = 11'd512; cyc();
        chk("R7 busy", busy, 0);
        chk("R7 remaining", remaining, 2000);
        chk("R7 reason", reason, 4'b0100);
        clear_all();
    endtask

    task automatic t_zero_and_reset();
        start(0);
        chk("R12 busy", busy, 0);
        chk("R12 reason", reason, 4'b0001);
        start(700);
        chk("R2 busy", busy, 1);
        cmd_reset = 1'b1; cyc();
        chk("R8 busy", busy, 0);
        chk("R8 remaining", remaining, 0);
        chk("R8 reason", reason, 0);
        chk("R8 irq", irq, 0);
    endtask

    task automatic t_busy_start_overflow();
        start(800);
        start(300);
        chk("R11 busy", busy, 1);
        chk("R11 remaining", remaining, 800);
        pkt(512);
        chk("R3 remaining", remaining, 288);
        pkt(512);
        chk("R13 remaining", remaining, 0);
        chk("R13 busy", busy, 0);
        chk("R13 reason", reason, 4'b1001);
    endtask

    task automatic t_clear_vs_set();
        start(10);
        pkt_valid = 1'b1; pkt_len = 11'd512; flag_clr = 4'b1001; cyc();
        chk("R9 set wins", reason, 4'b1001);
        flag_clr = 4'b1000; cyc();
        chk("R9 single clear", reason, 4'b0001);
        irq_en = 4'b0010; #1;
        chk("R10 masked", irq, 0);
        irq_en = 4'b0001; #1;
        chk("R10 enabled", irq, 1);
        irq_en = 4'hF;
        clear_all();
        chk("R9 all clear", reason, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        t_reset_state();
        t_full_packets();
        t_short_packets();
        t_short_final();
        t_stop();
        t_zero_and_reset();
        t_busy_start_overflow();
        t_clear_vs_set();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule